// File: doc/BRIEF.md
# Tower Tagger and Zero Suppressor

This block takes calorimeter words that have already been confirmed by the first-level accept and turns them into a stream of self-describing tower records. It has two input channels, one for each receiver mezzanine. Each input word is 40 bits wide and carries two towers. Each tower is 20 bits: a 10-bit electromagnetic value and a 10-bit hadronic value. With each word the channel also supplies a 2-bit cable index and a 2-bit trigger buffer number.

Each channel splits its word into the two towers and sends them one at a time. It gives each tower a 10-bit global index. The index is built from the fixed board number, the FPGA number, the channel's mezzanine number, the cable index and the tower's slot in the word. The channel also attaches the buffer number. Towers whose whole 20-bit energy is zero are dropped.

The surviving records go into a small FIFO, one per channel. A round-robin merger drains the two FIFOs into one registered 32-bit output with a valid flag. Packet header and trailer words are added further downstream.

Top module: `tower_tag_merge`

## Requirements
- R1: Each output word holds the tower energy in bits [31:12], the global tower index in bits [11:2] and the buffer number in bits [1:0].
- R2: The tower index equals board_id×32 + fpga_id×16 + mezzanine×8 + cable×2 + slot. Channel 0 is mezzanine 0 and channel 1 is mezzanine 1.
- R3: The tower in bits [19:0] of an input word is slot 0 and leaves before the tower in bits [39:20], which is slot 1. Within a tower, EM is bits [9:0] and HAD is bits [19:10]; the block keeps both together as one 20-bit field.
- R4: A tower whose 20 energy bits are all zero produces no output word. A tower with only EM energy, or only HAD energy, is kept.
- R5: An input word is taken on a clock edge where its valid and ready are both high. Ready stays low while that channel is still emitting the towers of a word it has taken.
- R6: When both channel FIFOs hold data, the output alternates between the channels on consecutive grants.
- R7: Records from one channel leave in the order they were produced. No record is lost or duplicated.
- R8: After reset, out_valid is low and both input ready signals are high.
- R9: Each channel FIFO holds 4 records. It is never written when full and never read when empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| board_id | input | 5 | Fixed board number |
| fpga_id | input | 1 | Fixed FPGA number on the board |
| in_valid | input | 2 | Word valid, one bit per channel |
| in_ready | output | 2 | Word accepted, one bit per channel |
| in_data | input | 2×40 | Two-tower word per channel, slot 0 in [19:0] |
| in_cable | input | 2×2 | Cable index per channel |
| in_bufn | input | 2×2 | Trigger buffer number per channel |
| out_valid | output | 1 | Output word valid |
| out_word | output | 32 | Tagged tower record |

## Verification
The assertions assume two things about the inputs. First, an offered word, with its cable and buffer fields, stays unchanged until it is taken. Second, board_id and fpga_id change only while the block is idle.

The stimulus respects both. It holds each word from one falling edge until ready has been seen at a rising edge. It changes the identity inputs only after the output stream has drained.

Expected records are built in the bench from the index formula and kept in one queue per channel. Each output is matched against the queue named by its mezzanine bit. This checks content and per-channel order whatever the arbitration timing. A separate scenario loads both channels at once and checks that consecutive outputs come from alternating channels.

// File: rtl/tower_tag_pkg.sv
package tower_tag_pkg;
    localparam int ENERGY_W  = 20;
    localparam int IDX_W     = 10;
    localparam int BUFN_W    = 2;
    localparam int CABLE_W   = 2;
    localparam int BOARD_W   = 5;
    localparam int SLOTS     = 2;
    localparam int IN_W      = ENERGY_W * SLOTS;
    localparam int N_CH      = 2;
    localparam int REC_W     = ENERGY_W + IDX_W + BUFN_W;

    typedef struct packed {
        logic [ENERGY_W-1:0] energy;
        logic [IDX_W-1:0]    idx;
        logic [BUFN_W-1:0]   bufn;
    } tower_rec_t;
endpackage

// File: rtl/tower_splitter.sv
module tower_splitter
    import tower_tag_pkg::*;
#(
    parameter logic MEZZ = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [BOARD_W-1:0]  board_id,
    input  logic                fpga_id,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [IN_W-1:0]     in_data,
    input  logic [CABLE_W-1:0]  in_cable,
    input  logic [BUFN_W-1:0]   in_bufn,
    input  logic                fifo_full,
    output logic                push,
    output tower_rec_t          push_rec
);
    typedef struct packed {
        logic                hold;
        logic                slot;
        logic [IN_W-1:0]     data;
        logic [CABLE_W-1:0]  cable;
        logic [BUFN_W-1:0]   bufn;
    } split_st_t;

    split_st_t st_d, st_q;
    logic [ENERGY_W-1:0] cur_e;
    logic keep, step;

    always_comb begin
        st_d     = st_q;
        cur_e    = st_q.slot ? st_q.data[IN_W-1:ENERGY_W] : st_q.data[ENERGY_W-1:0];
        keep     = |cur_e;
        step     = st_q.hold && (!keep || !fifo_full);
        push     = st_q.hold && keep && !fifo_full;
        push_rec = '{energy: cur_e,
                     idx:    {board_id, fpga_id, MEZZ, st_q.cable, st_q.slot},
                     bufn:   st_q.bufn};
        in_ready = !st_q.hold;
        if (!st_q.hold) begin
            if (in_valid) begin
                st_d.hold  = 1'b1;
                st_d.slot  = 1'b0;
                st_d.data  = in_data;
                st_d.cable = in_cable;
                st_d.bufn  = in_bufn;
            end
        end else if (step) begin
            if (st_q.slot) st_d.hold = 1'b0;
            else           st_d.slot = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5: an offered word waits unchanged until taken (input assumption)
    assert_input_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_ready) |=> (in_valid && $stable(in_data) && $stable(in_cable)));
    // R5: after a word is taken, ready drops for at least one cycle
    assert_busy_after_take_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);
endmodule

// File: rtl/tower_fifo.sv
module tower_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    output logic         full,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty
);
    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW:0]             wp;
        logic [AW:0]             rp;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        empty = (st_q.wp == st_q.rp);
        full  = (st_q.wp[AW] != st_q.rp[AW]) && (st_q.wp[AW-1:0] == st_q.rp[AW-1:0]);
        dout  = st_q.mem[st_q.rp[AW-1:0]];
        if (push) begin
            st_d.mem[st_q.wp[AW-1:0]] = din;
            st_d.wp = st_q.wp + 1'b1;
        end
        if (pop) st_d.rp = st_q.rp + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/tower_rr_merge.sv
module tower_rr_merge
    import tower_tag_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_CH-1:0]   empty,
    input  tower_rec_t        head0,
    input  tower_rec_t        head1,
    output logic [N_CH-1:0]   pop,
    output logic              out_valid,
    output logic [REC_W-1:0]  out_word
);
    typedef struct packed {
        logic             last;
        logic             ov;
        logic [REC_W-1:0] ow;
    } merge_st_t;

    merge_st_t st_d, st_q;
    logic [N_CH-1:0] req;

    always_comb begin
        st_d    = st_q;
        req     = ~empty;
        pop     = '0;
        st_d.ov = 1'b0;
        if (req == 2'b11) pop[!st_q.last] = 1'b1;
        else              pop = req;
        if (pop[0]) begin
            st_d.ov = 1'b1; st_d.ow = head0; st_d.last = 1'b0;
        end else if (pop[1]) begin
            st_d.ov = 1'b1; st_d.ow = head1; st_d.last = 1'b1;
        end
        out_valid = st_q.ov;
        out_word  = st_q.ow;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_rr_turn0_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop[0] && !empty[1]) |=> pop[1]);
    assert_rr_turn1_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop[1] && !empty[0]) |=> pop[0]);
    assert_one_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pop));
endmodule

// File: rtl/tower_tag_merge.sv
module tower_tag_merge
    import tower_tag_pkg::*;
#(
    parameter int FIFO_DEPTH = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [BOARD_W-1:0]              board_id,
    input  logic                            fpga_id,
    input  logic [N_CH-1:0]                 in_valid,
    output logic [N_CH-1:0]                 in_ready,
    input  logic [N_CH-1:0][IN_W-1:0]       in_data,
    input  logic [N_CH-1:0][CABLE_W-1:0]    in_cable,
    input  logic [N_CH-1:0][BUFN_W-1:0]     in_bufn,
    output logic                            out_valid,
    output logic [REC_W-1:0]                out_word
);
    logic [N_CH-1:0] push, full, pop, empty;
    tower_rec_t push_rec [N_CH];
    tower_rec_t head     [N_CH];

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        tower_splitter #(.MEZZ(c[0])) u_split (
            .clk(clk), .rst_n(rst_n), .board_id(board_id), .fpga_id(fpga_id),
            .in_valid(in_valid[c]), .in_ready(in_ready[c]), .in_data(in_data[c]),
            .in_cable(in_cable[c]), .in_bufn(in_bufn[c]), .fifo_full(full[c]),
            .push(push[c]), .push_rec(push_rec[c]));
        tower_fifo #(.DEPTH(FIFO_DEPTH), .W(REC_W)) u_fifo (
            .clk(clk), .rst_n(rst_n), .push(push[c]), .din(push_rec[c]),
            .full(full[c]), .pop(pop[c]), .dout(head[c]), .empty(empty[c]));
    end

    tower_rr_merge u_merge (
        .clk(clk), .rst_n(rst_n), .empty(empty), .head0(head[0]), .head1(head[1]),
        .pop(pop), .out_valid(out_valid), .out_word(out_word));

    // R4: no zero-energy record ever reaches the output
    assert_no_zero_out_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_word[REC_W-1:REC_W-ENERGY_W] != '0));
    // R2: output index carries the FPGA number (identity held while busy)
    assert_index_fpga_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_word[BUFN_W+4] == fpga_id));
endmodule

// File: tb/tower_tag_merge_test.sv
module tower_tag_merge_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [4:0] board_id = 5'd0;
    logic fpga_id = 1'b0;
    logic [1:0] in_valid = '0;
    logic [1:0] in_ready;
    logic [1:0][39:0] in_data = '0;
    logic [1:0][1:0] in_cable = '0;
    logic [1:0][1:0] in_bufn = '0;
    logic out_valid;
    logic [31:0] out_word;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp0 [$];
    logic [31:0] exp1 [$];
    bit rr_mode = 0;
    int last_ch = -1;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tower_tag_merge uut (
        .clk(clk), .rst_n(rst_n), .board_id(board_id), .fpga_id(fpga_id),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_cable(in_cable), .in_bufn(in_bufn), .out_valid(out_valid), .out_word(out_word));

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    function automatic logic [31:0] mk(input int ch, input logic [1:0] cab, input int slot,
                                       input logic [19:0] e, input logic [1:0] b);
        int idx;
        idx = board_id * 32 + fpga_id * 16 + ch * 8 + cab * 2 + slot;
        return {e, idx[9:0], b};
    endfunction

    // monitor: R1 R2 R3 R7 content and per-channel order; R6 alternation
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            int ch;
            logic [31:0] e;
            ch = out_word[5];
            if (ch == 0 && exp0.size() > 0) begin e = exp0.pop_front(); check(out_word == e, "R1 R2 R3 R7 ch0", out_word, e); end
            else if (ch == 1 && exp1.size() > 0) begin e = exp1.pop_front(); check(out_word == e, "R1 R2 R3 R7 ch1", out_word, e); end
            else check(0, "R4 R7 unexpected word", out_word, 32'h0);
            if (rr_mode && last_ch >= 0)
                check(ch != last_ch, "R6 alternation", ch, 1 - last_ch);
            last_ch = ch;
        end
    end

    task automatic send(input int ch, input logic [39:0] d, input logic [1:0] cab, input logic [1:0] b);
        logic r;
        if (d[19:0] != 0)  begin if (ch == 0) exp0.push_back(mk(ch, cab, 0, d[19:0], b));  else exp1.push_back(mk(ch, cab, 0, d[19:0], b)); end
        if (d[39:20] != 0) begin if (ch == 0) exp0.push_back(mk(ch, cab, 1, d[39:20], b)); else exp1.push_back(mk(ch, cab, 1, d[39:20], b)); end
        @(negedge clk);
        in_valid[ch] = 1'b1; in_data[ch] = d; in_cable[ch] = cab; in_bufn[ch] = b;
        while (1) begin
            r = in_ready[ch];
            @(negedge clk);
            if (r) break;
        end
        in_valid[ch] = 1'b0;
    endtask

    task automatic drain(input string tag);
        repeat (30) @(negedge clk);
        check(exp0.size() == 0 && exp1.size() == 0, tag, exp0.size() + exp1.size(), 0);
    endtask

    task automatic test_reset;
        @(negedge clk);
        check(out_valid == 1'b0, "R8 out_valid", out_valid, 0);
        check(in_ready == 2'b11, "R8 in_ready", in_ready, 2'b11);
    endtask

    task automatic test_layout;
        board_id = 5'd17; fpga_id = 1'b1;
        send(0, {20'h12345, 20'h0ABCD}, 2'd2, 2'd3);   // R1 R2 R3
        send(1, {20'h00001, 20'hFFFFF}, 2'd3, 2'd1);
        drain("R1 R2 layout drained");
    endtask

    task automatic test_busy;
        board_id = 5'd3; fpga_id = 1'b0;
        send(0, {20'h00010, 20'h00020}, 2'd0, 2'd0);
        check(in_ready[0] == 1'b0, "R5 ready low after take", in_ready[0], 0);
        drain("R5 busy drained");
    endtask

    task automatic test_zero;
        board_id = 5'd9; fpga_id = 1'b1;
        send(0, 40'h0, 2'd1, 2'd2);                        // R4 both dropped
        send(0, {20'h00000, 20'h003FF}, 2'd1, 2'd2);       // R4 EM only, slot1 dropped
        send(1, {20'hFFC00, 20'h00000}, 2'd0, 2'd1);       // R4 HAD only, slot0 dropped
        send(1, {20'h00400, 20'h00000}, 2'd2, 2'd0);
        drain("R4 zero suppression drained");
    endtask

    task automatic test_burst;
        board_id = 5'd31; fpga_id = 1'b1;
        for (int i = 0; i < 12; i++)
            send(1, {20'(i * 7 + 1), 20'(i * 3 + 5)}, 2'(i), 2'(i + 1));  // R7 R9
        drain("R7 R9 burst drained");
    endtask

    task automatic test_rr;
        board_id = 5'd5; fpga_id = 1'b0;
        last_ch = -1; rr_mode = 1;
        fork
            for (int i = 0; i < 6; i++) send(0, {20'(i + 100), 20'(i + 1)}, 2'(i), 2'd1);
            for (int i = 0; i < 6; i++) send(1, {20'(i + 200), 20'(i + 50)}, 2'(i), 2'd2);
        join
        drain("R6 R9 round robin drained");
        rr_mode = 0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_layout();
        test_busy();
        test_zero();
        test_burst();
        test_rr();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule